// File: doc/BRIEF.md
# SMBus Indexed Block Configuration Register Target

This block is a target-only SMBus port. It holds eight 8-bit configuration registers and drives their contents in parallel to the clock-control logic of a clock generator. It answers on one fixed 7-bit address. Both transfers are indexed block transfers. A write carries a register offset, a byte count and that many data bytes. A read first sets the offset in write direction. A repeated START in read direction follows. The target then returns a count byte and streams data from the indexed register onward.

SCL and SDA enter through a two-flop synchronizer and are sampled on the system clock. The target pulls SDA low through an open-drain enable, and only while SCL is low. Either START or STOP aborts any transfer in progress. The active-low power-down input holds every register at its power-up default.

Top module: `smbreg_top`

## Requirements
- R1: Only the 7-bit address 1101001 is answered, which is 0xD2 for write and 0xD3 for read. A byte with any other address is not acknowledged (SDA stays high in its ninth clock), and the rest of that transfer is ignored.
- R2: A write is START, 0xD2, offset, count N, then data bytes. Each accepted byte is acknowledged. Each acknowledged data byte is committed at once into the register at the pointer, and the pointer then increments. Register i drives `cfgBank[8i+7:8i]`.
- R3: A count byte of zero is not acknowledged, and the whole transfer is discarded: later data bytes are NACKed and no register changes.
- R4: A read is START, 0xD2, offset, repeated START, 0xD3. The target sends a count byte equal to 8 minus the offset, or 0 when the offset is 8 or more. It then sends data from the offset upward, advancing after each master ACK, until the master NACKs.
- R5: Register defaults are 0x35, 0xF0, 0x80, 0x06, 0x00, 0x00, 0x03 and 0x00 for offsets 0 to 7. They hold from reset, and while `pdRstN` is low.
- R6: Some bits are read-only and keep their value on writes. These are bits 4..0 of offset 2, bit 0 of offset 3, and all of offsets 4, 5, 6 (the fixed ID byte 0x03) and 7. Reserved bits read as zero.
- R7: Once the pointer passes offset 7, write data bytes are NACKed and read data bytes return 0x00.
- R8: Data bytes beyond the count N are NACKed and not written.
- R9: A STOP, or a new START, in the middle of a byte aborts the transfer. A partially received byte is never written.
- R10: The target changes its SDA pull-down only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| pdRstN | input | 1 | Active-low power-down reset; forces register defaults |
| sclIn | input | 1 | SMBus clock line as seen on the bus |
| sdaIn | input | 1 | SMBus data line as seen on the bus |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| cfgBank | output | 64 | Register contents, offset i at bits 8i+7..8i |

## Verification
The embedded properties check several rules on every cycle. No acknowledge may follow a foreign address or a zero count. STOP must always return the engine to idle with SDA released. Commits may happen only with the pointer in range. The pointer must stay saturated at 8, and reserved bits must stay zero. Only the bench scenarios can show the rest. These are the byte order of block transfers, the count byte value, the read-back of masked bits, and discards after NACKs or aborted bytes. Also the return to defaults on a power-down pulse and SDA timing seen from the bus side.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;
  localparam int NREG = 8;
  localparam int DW   = 8;
  localparam int IDXW = $clog2(NREG);
  localparam int PTRW = IDXW + 1;

  typedef struct packed {
    logic          loadPtr;
    logic          wrEn;
    logic          advance;
    logic [DW-1:0] val;
  } strobe_t;

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK} state_t;
  typedef enum logic [1:0] {K_ADDR, K_OFFS, K_CNT, K_DATA} kind_t;

  function automatic logic [DW-1:0] regDefault(input int idx);
    case (idx)
      0: return 8'h35;
      1: return 8'hF0;
      2: return 8'h80;
      3: return 8'h06;
      6: return 8'h03;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [DW-1:0] regWrMask(input int idx);
    case (idx)
      0, 1: return 8'hFF;
      2: return 8'hE0;
      3: return 8'hFE;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
  import smbreg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          pdRstN,
  input  logic          sclIn,
  input  logic          sdaIn,
  input  logic          ptrInRange,
  input  logic [DW-1:0] txCount,
  input  logic [DW-1:0] txData,
  output strobe_t       str,
  output logic          sdaLow
);
  logic [SYNC_STAGES:0] sclPipe, sdaPipe;
  logic sclS, sclQ, sdaS, sdaQ;
  logic sclRise, sclFall, busStart, busStop;

  always_ff @(posedge clk or negedge pdRstN) begin
    if (!pdRstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-1:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-1:0], sdaIn};
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sclQ = sclPipe[SYNC_STAGES];
  assign sdaS = sdaPipe[SYNC_STAGES-1];
  assign sdaQ = sdaPipe[SYNC_STAGES];
  assign sclRise  = sclS & ~sclQ;
  assign sclFall  = ~sclS & sclQ;
  assign busStart = sclS & sclQ & sdaQ & ~sdaS;
  assign busStop  = sclS & sclQ & ~sdaQ & sdaS;

  state_t        state;
  kind_t         kind;
  logic [3:0]    bitCnt;
  logic [DW-1:0] shReg, txReg, remCnt;
  logic          rdMode, txIsCnt, mAcked;
  logic          byteDone, rxAck;

  assign byteDone = (state == S_RX) && (bitCnt == 4'd8) && sclFall;

  always_comb begin
    case (kind)
      K_ADDR:  rxAck = (shReg[7:1] == SLAVE_ADDR);
      K_OFFS:  rxAck = 1'b1;
      K_CNT:   rxAck = (shReg != '0);
      default: rxAck = (remCnt != '0) && ptrInRange;
    endcase
  end

  always_comb begin
    str         = '0;
    str.val     = shReg;
    str.loadPtr = byteDone && (kind == K_OFFS);
    str.wrEn    = byteDone && (kind == K_DATA) && rxAck;
    str.advance = (state == S_TXACK) && sclRise && !sdaS && !txIsCnt;
  end

  always_ff @(posedge clk or negedge pdRstN) begin
    if (!pdRstN) begin
      state <= S_IDLE; kind <= K_ADDR; bitCnt <= '0; shReg <= '0;
      txReg <= '0; remCnt <= '0; rdMode <= 1'b0; txIsCnt <= 1'b0;
      mAcked <= 1'b0; sdaLow <= 1'b0;
    end else if (busStop) begin
      state <= S_IDLE; sdaLow <= 1'b0;
    end else if (busStart) begin
      state <= S_RX; kind <= K_ADDR; bitCnt <= '0;
      rdMode <= 1'b0; sdaLow <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (sclRise) begin
            shReg  <= {shReg[DW-2:0], sdaS};
            bitCnt <= bitCnt + 4'd1;
          end else if (byteDone) begin
            if (rxAck) begin
              sdaLow <= 1'b1;
              state  <= S_RXACK;
              case (kind)
                K_ADDR: begin rdMode <= shReg[0]; kind <= K_OFFS; end
                K_OFFS: kind <= K_CNT;
                K_CNT:  begin remCnt <= shReg; kind <= K_DATA; end
                default: remCnt <= remCnt - 8'd1;
              endcase
            end else begin
              state <= S_IDLE;
            end
          end
        end
        S_RXACK: if (sclFall) begin
          bitCnt <= '0;
          if (rdMode) begin
            state   <= S_TX;
            txReg   <= txCount;
            sdaLow  <= ~txCount[7];
            txIsCnt <= 1'b1;
          end else begin
            state  <= S_RX;
            sdaLow <= 1'b0;
          end
        end
        S_TX: begin
          if (sclRise) bitCnt <= bitCnt + 4'd1;
          else if (sclFall) begin
            if (bitCnt == 4'd8) begin
              sdaLow <= 1'b0;
              mAcked <= 1'b0;
              state  <= S_TXACK;
            end else begin
              txReg  <= {txReg[DW-2:0], 1'b0};
              sdaLow <= ~txReg[6];
            end
          end
        end
        S_TXACK: begin
          if (sclRise) begin
            if (sdaS) state <= S_IDLE;
            else mAcked <= 1'b1;
          end else if (sclFall && mAcked) begin
            state   <= S_TX;
            bitCnt  <= '0;
            txReg   <= txData;
            sdaLow  <= ~txData[7];
            txIsCnt <= 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  a_r1_no_ack_foreign: assert property (@(posedge clk) disable iff (!pdRstN)
    (byteDone && kind == K_ADDR && shReg[7:1] != SLAVE_ADDR) |=> !sdaLow);
  a_r3_zero_count_nack: assert property (@(posedge clk) disable iff (!pdRstN)
    (byteDone && kind == K_CNT && shReg == '0) |=> (!sdaLow && state == S_IDLE));
  a_r9_stop_aborts: assert property (@(posedge clk) disable iff (!pdRstN)
    busStop |=> (state == S_IDLE && !sdaLow));
  a_r10_sda_scl_low: assert property (@(posedge clk) disable iff (!pdRstN)
    (!$stable(sdaLow) && !$past(busStart) && !$past(busStop)) |-> !sclS);
endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank
  import smbreg_pkg::*;
(
  input  logic               clk,
  input  logic               pdRstN,
  input  strobe_t            str,
  output logic               ptrInRange,
  output logic [DW-1:0]      txCount,
  output logic [DW-1:0]      txData,
  output logic [NREG*DW-1:0] cfgBank
);
  logic [PTRW-1:0] ptr;
  logic [DW-1:0]   regQ [NREG];

  assign ptrInRange = (ptr < PTRW'(NREG));

  always_ff @(posedge clk or negedge pdRstN) begin
    if (!pdRstN) ptr <= '0;
    else if (str.loadPtr)
      ptr <= (str.val >= DW'(NREG)) ? PTRW'(NREG) : PTRW'(str.val);
    else if ((str.wrEn || str.advance) && ptrInRange)
      ptr <= ptr + PTRW'(1);
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam logic [DW-1:0] DEF  = regDefault(i);
    localparam logic [DW-1:0] MASK = regWrMask(i);
    always_ff @(posedge clk or negedge pdRstN) begin
      if (!pdRstN) regQ[i] <= DEF;
      else if (str.wrEn && ptr == PTRW'(i))
        regQ[i] <= (str.val & MASK) | (regQ[i] & ~MASK);
    end
    assign cfgBank[i*DW +: DW] = regQ[i];
  end

  assign txData  = ptrInRange ? regQ[ptr[IDXW-1:0]] : '0;
  assign txCount = ptrInRange ? (DW'(NREG) - DW'(ptr)) : '0;

  a_r7_write_in_range: assert property (@(posedge clk) disable iff (!pdRstN)
    str.wrEn |-> ptrInRange);
  a_r7_ptr_saturates: assert property (@(posedge clk) disable iff (!pdRstN)
    ptr <= PTRW'(NREG));
  a_r6_reserved_zero: assert property (@(posedge clk) disable iff (!pdRstN)
    (regQ[2][4:0] == 5'd0 && regQ[3][0] == 1'b0 && regQ[4] == '0 && regQ[5] == '0));
  a_r2_write_changes_one: assert property (@(posedge clk) disable iff (!pdRstN)
    !str.wrEn |=> $stable(cfgBank));
endmodule

// File: rtl/smbreg_top.sv
module smbreg_top
  import smbreg_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               pdRstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  output logic               sdaPullLow,
  output logic [NREG*DW-1:0] cfgBank
);
  strobe_t       str;
  logic          ptrInRange;
  logic [DW-1:0] txCount, txData;

  smbreg_ctrl #(.SLAVE_ADDR(SLAVE_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .pdRstN(pdRstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .ptrInRange(ptrInRange), .txCount(txCount), .txData(txData),
    .str(str), .sdaLow(sdaPullLow));

  smbreg_bank u_bank (
    .clk(clk), .pdRstN(pdRstN), .str(str), .ptrInRange(ptrInRange),
    .txCount(txCount), .txData(txData), .cfgBank(cfgBank));
endmodule

// File: tb/smbreg_top_tb.sv
module smbreg_top_tb;
  localparam int Q = 8;
  localparam logic [63:0] DEF = 64'h0003_0000_0680_F035;
  // {offset, written value, expected read value}
  localparam logic [23:0] VEC [8] = '{
    24'h00_A5_A5, 24'h01_0F_0F, 24'h02_FF_E0, 24'h03_FF_FE,
    24'h04_FF_00, 24'h05_55_00, 24'h06_FF_03, 24'h07_FF_00};

  logic clk = 1'b0, pdRstN = 1'b0, mScl = 1'b1, mSda = 1'b1;
  logic sdaPullLow, sdaBus;
  logic [63:0] cfgBank, expBank;
  int total = 0, bad = 0, sdaViol = 0, sclHigh = 0;
  logic [7:0] rdCount, rdAcks;
  logic [7:0] rdBuf [9];
  logic prevPull = 1'b0;

  always #4 clk = ~clk;
  assign sdaBus = mSda & ~sdaPullLow;

  smbreg_top u_dut (.clk(clk), .pdRstN(pdRstN), .sclIn(mScl), .sdaIn(sdaBus),
                    .sdaPullLow(sdaPullLow), .cfgBank(cfgBank));

  // R10 bus monitor: pull-down must not move during a settled SCL high
  always @(negedge clk) begin
    sclHigh <= mScl ? sclHigh + 1 : 0;
    if (mScl && sclHigh > 4 && sdaPullLow != prevPull) sdaViol <= sdaViol + 1;
    prevPull <= sdaPullLow;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic busStart();
    mSda = 1'b1; w(Q); mScl = 1'b1; w(Q); mSda = 1'b0; w(Q); mScl = 1'b0; w(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; w(Q); mScl = 1'b1; w(Q); mSda = 1'b1; w(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; w(Q); mScl = 1'b1; w(2*Q); mScl = 1'b0; w(Q);
    end
    mSda = 1'b1; w(Q); mScl = 1'b1; w(Q); ack = ~sdaBus; w(Q); mScl = 1'b0; w(Q);
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(Q); mScl = 1'b1; w(Q); b[i] = sdaBus; w(Q); mScl = 1'b0;
    end
    w(Q); mSda = ~ackIt; w(Q); mScl = 1'b1; w(2*Q); mScl = 1'b0; mSda = 1'b1; w(Q);
  endtask

  task automatic wrTx(input logic [7:0] adr, input logic [7:0] off, input logic [7:0] cnt,
                      input int n, input logic [23:0] dat, output logic [7:0] acks);
    logic a;
    acks = '0;
    busStart();
    sendByte(adr, a); acks[0] = a;
    sendByte(off, a); acks[1] = a;
    sendByte(cnt, a); acks[2] = a;
    for (int i = 0; i < n; i++) begin
      sendByte(dat[23-8*i -: 8], a); acks[3+i] = a;
    end
    busStop(); w(2*Q);
  endtask

  task automatic rdTx(input logic [7:0] off, input int n);
    logic a;
    rdAcks = '0;
    busStart();
    sendByte(8'hD2, a); rdAcks[0] = a;
    sendByte(off, a);   rdAcks[1] = a;
    busStart();
    sendByte(8'hD3, a); rdAcks[2] = a;
    recvByte(1'b1, rdCount);
    for (int i = 0; i < n; i++) recvByte(i != n - 1, rdBuf[i]);
    busStop(); w(2*Q);
  endtask

  initial begin
    logic [7:0] acks;
    w(5); pdRstN = 1'b1; w(5);
    expBank = DEF;
    check("R5 reset defaults", cfgBank, DEF);

    // R2 R6 R4: single-byte write/readback per register
    for (int v = 0; v < 8; v++) begin
      logic [7:0] o, d, e;
      {o, d, e} = VEC[v];
      wrTx(8'hD2, o, 8'd1, 1, {d, 16'h0}, acks);
      check("R2 write acks", acks, 8'h0F);
      expBank[8*o +: 8] = e;
      check("R6 masked bank", cfgBank, expBank);
      rdTx(o, 1);
      check("R4 count byte", rdCount, 8'(8 - o));
      check("R6 readback", rdBuf[0], e);
    end

    // R2 burst write, pointer increments, masks on offset 2
    wrTx(8'hD2, 8'd0, 8'd3, 3, 24'h11_22_33, acks);
    check("R2 burst acks", acks, 8'h3F);
    expBank[23:0] = 24'h20_22_11;
    check("R2 burst bank", cfgBank, expBank);

    // R4 full read from offset 0
    rdTx(8'd0, 8);
    check("R4 read addr acks", rdAcks, 8'h07);
    check("R4 full count", rdCount, 8'd8);
    for (int i = 0; i < 8; i++) check("R4 stream data", rdBuf[i], expBank[8*i +: 8]);

    // R4 mid read from offset 5
    rdTx(8'd5, 3);
    check("R4 mid count", rdCount, 8'd3);
    check("R4 mid data", {rdBuf[0], rdBuf[1], rdBuf[2]}, {expBank[47:40], expBank[55:48], expBank[63:56]});

    // R3 zero count discarded
    wrTx(8'hD2, 8'd0, 8'd0, 1, 24'h99_0000, acks);
    check("R3 zero count acks", acks, 8'h03);
    check("R3 no change", cfgBank, expBank);

    // R1 foreign address
    wrTx(8'hD4, 8'd0, 8'd1, 1, 24'h77_0000, acks);
    check("R1 foreign acks", acks, 8'h00);
    check("R1 no change", cfgBank, expBank);

    // R8 bytes beyond count
    wrTx(8'hD2, 8'd0, 8'd1, 2, 24'h77_8800, acks);
    check("R8 acks", acks, 8'h0F);
    expBank[7:0] = 8'h77;
    check("R8 bank", cfgBank, expBank);

    // R7 write past offset 7, read past end
    wrTx(8'hD2, 8'd7, 8'd2, 2, 24'hAA_BB00, acks);
    check("R7 write acks", acks, 8'h0F);
    check("R7 bank", cfgBank, expBank);
    rdTx(8'd9, 1);
    check("R7 count", rdCount, 8'd0);
    check("R7 data", rdBuf[0], 8'h00);

    // R9 STOP in the middle of a data byte
    begin
      logic a;
      busStart();
      sendByte(8'hD2, a); sendByte(8'd1, a); sendByte(8'd1, a);
      for (int i = 0; i < 4; i++) begin
        mSda = 1'b0; w(Q); mScl = 1'b1; w(2*Q); mScl = 1'b0; w(Q);
      end
      busStop(); w(2*Q);
    end
    check("R9 abort", cfgBank, expBank);
    wrTx(8'hD2, 8'd1, 8'd1, 1, 24'h5A_0000, acks);
    expBank[15:8] = 8'h5A;
    check("R9 recovery", cfgBank, expBank);

    // R5 power-down pulse
    pdRstN = 1'b0; w(3);
    check("R5 held in power-down", cfgBank, DEF);
    pdRstN = 1'b1; w(3);
    check("R5 after power-down", cfgBank, DEF);

    check("R10 sda moves only while scl low", 64'(sdaViol), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule